// File: doc/BRIEF.md
# Audio Transmit FIFO with Sample Packing

This block is the transmit half of a serial audio codec link. A host writes 32-bit words to a data register. Each word becomes one or two 20-bit samples. A sample narrower than 20 bits is shifted up, so that its most significant bit sits at bit 19. The samples are queued in a circular buffer of `DEPTH` entries. Once enough of them are waiting, the block sends them out as left/right pairs on a valid/ready port that feeds the codec-side serializer.

A small register file holds the transmit controls, an interface enable, an interrupt enable mask and an interrupt clear strobe. It also provides read-back of a status word and of the raw interrupt bits. The status word holds the empty, half-empty, full and underrun flags. A single interrupt line is high whenever a raw interrupt bit and its enable bit are both set. Clearing the interface enable returns the whole block to its reset state.

Top module: `atx_txfifo`

## Requirements
- R1: The transmit control register is at address 0. Its fields are: bit 0 transmit enable, bits 2:1 width code, bit 3 packed mode, bit 4 slot-3 select and bit 5 slot-4 select. Width code 0 selects 16 bits, 1 selects 18, 2 selects 20 and 3 selects 12. A single-sample write to the data register (address 2) stores the write data shifted left by 4, 2, 0 or 8 places for codes 0, 1, 2 or 3, keeping only bits 19:0.
- R2: In packed mode a data write stores two samples: bits 15:0 first, then bits 31:16. Each is shifted left by 8 for width code 3, by 4 otherwise, and truncated to 20 bits. Packed mode has no effect when the width code is 1 or 2; each write then stores one sample as in R1.
- R3: A single-sample write is discarded when the FIFO holds `DEPTH` samples. A packed write is accepted only if the current level plus two is strictly less than `DEPTH`.
- R4: The status register is read at address 5. Its bits are: 0 transmit empty, 1 half-empty, 2 full, 3 underrun and 4 receive empty. On every data write the new level updates the flags. A nonzero level clears empty and underrun, a level of at least `DEPTH/2` clears half-empty, and a level of `DEPTH` sets full.
- R5: The output port presents a pair only when transmit is enabled, at least one slot select is set and at least two samples are queued. A pair starts only once the level reaches `DEPTH/2`. Pairs leave in write order, with the older sample on `pair_left`.
- R6: After a pair is accepted, the block keeps presenting pairs while at least two samples remain. If the codec refuses a presented pair (valid high, ready low), the burst ends, and no pair is offered again until the level reaches `DEPTH/2`.
- R7: After an accepted pair, full clears. Half-empty sets if the new level is at most `DEPTH/2`. Empty and underrun both set if the new level is zero.
- R8: The raw interrupt register is read at address 6. Its bit 0 follows half-empty and bit 1 follows underrun. Bit 2 is set when the FIFO is empty and no pair is being presented. The enable mask is at address 4, and `irq` is high when any raw bit and its enable bit are both set.
- R9: Writing a 1 in bit 0 of the clear register (address 3) clears the underrun flag. Bits 31:3 of the raw interrupt read are always zero.
- R10: The interface enable register is at address 1, bit 0. Reset, or a write to it with bit 0 low, empties the FIFO and zeroes the control and enable registers. The status then reads 0x13: receive empty, half-empty and transmit empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Write address |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 3 | Read address |
| bus_rdata | output | 32 | Read data for `bus_raddr` (combinational) |
| pair_valid | output | 1 | A sample pair is offered to the codec |
| pair_ready | input | 1 | Codec accepts the offered pair |
| pair_left | output | 20 | Older sample of the pair |
| pair_right | output | 20 | Newer sample of the pair |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions check on every cycle that the level never exceeds the depth and that an offered pair always has two queued samples behind an enabled slot. They also check that a refused pair holds its data, that an accepted pair drops the level by exactly two, and that the full and empty flags agree with the level. Only the bench scenarios can show the padding and packing arithmetic for every width and mode and the write-drop limits. The same holds for the half-depth start threshold, the end of a burst after a refusal, and the interrupt and clear behaviour, which are reached through sequences of register writes.

// File: rtl/atx_pkg.sv
package atx_pkg;
  localparam int SMP_W = 20;
  typedef logic [SMP_W-1:0] smp_t;

  typedef enum logic [1:0] {SZ16 = 2'd0, SZ18 = 2'd1, SZ20 = 2'd2, SZ12 = 2'd3} size_e;

  typedef struct packed {
    logic  slot4;
    logic  slot3;
    logic  packed_md;
    size_e size;
    logic  tx_en;
  } txctl_t;

  typedef struct packed {
    logic rx_empty;
    logic underrun;
    logic full;
    logic half_empty;
    logic empty;
  } txstat_t;

  localparam logic [2:0] ADR_TXCTL = 3'd0;
  localparam logic [2:0] ADR_IFCTL = 3'd1;
  localparam logic [2:0] ADR_DATA  = 3'd2;
  localparam logic [2:0] ADR_ICLR  = 3'd3;
  localparam logic [2:0] ADR_IEN   = 3'd4;
  localparam logic [2:0] ADR_STAT  = 3'd5;
  localparam logic [2:0] ADR_ISTAT = 3'd6;

  localparam txstat_t STAT_RESET = '{rx_empty: 1'b1, underrun: 1'b0, full: 1'b0,
                                     half_empty: 1'b1, empty: 1'b1};

  // Single-sample padding: left-justify by width, keep 20 bits.
  function automatic smp_t pad_single(size_e sz, logic [31:0] v);
    logic [31:0] s;
    case (sz)
      SZ16:    s = v << 4;
      SZ18:    s = v << 2;
      SZ20:    s = v;
      default: s = v << 8;
    endcase
    return s[SMP_W-1:0];
  endfunction

  // Packed-half padding: 12-bit shifts by 8, anything else by 4.
  function automatic smp_t pad_half(size_e sz, logic [15:0] h);
    logic [23:0] s;
    s = (sz == SZ12) ? {h, 8'h00} : {4'h0, h, 4'h0};
    return s[SMP_W-1:0];
  endfunction

  function automatic logic packing_on(txctl_t c);
    return c.packed_md && (c.size != SZ18) && (c.size != SZ20);
  endfunction
endpackage

// File: rtl/atx_packer.sv
module atx_packer
  import atx_pkg::*;
(
  input  txctl_t      ctl,
  input  logic [31:0] word,
  output smp_t        s0,
  output smp_t        s1,
  output logic        two
);
  always_comb begin
    two = packing_on(ctl);
    if (two) begin
      s0 = pad_half(ctl.size, word[15:0]);
      s1 = pad_half(ctl.size, word[31:16]);
    end else begin
      s0 = pad_single(ctl.size, word);
      s1 = '0;
    end
  end
endmodule

// File: rtl/atx_ring.sv
module atx_ring
  import atx_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [1:0]    push_cnt,
  input  smp_t          d0,
  input  smp_t          d1,
  input  logic          pop,
  output smp_t          head0,
  output smp_t          head1,
  output logic [LW-1:0] level,
  output logic [LW-1:0] level_nxt
);
  smp_t          mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push_cnt != 2'd0) mem[wp] <= d0;
    if (push_cnt == 2'd2) mem[wp + AW'(1)] <= d1;
  end

  always_comb
    level_nxt = level + LW'(push_cnt) - (pop ? LW'(2) : LW'(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      wp    <= wp + AW'(push_cnt);
      rp    <= rp + (pop ? AW'(2) : AW'(0));
      level <= level_nxt;
    end
  end

  assign head0 = mem[rp];
  assign head1 = mem[rp + AW'(1)];
endmodule

// File: rtl/atx_status.sv
module atx_status
  import atx_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_evt,
  input  logic          pop_evt,
  input  logic          uclr,
  input  logic [LW-1:0] lvl_nxt,
  output txstat_t       st
);
  localparam logic [LW-1:0] HALF_L = LW'(DEPTH / 2);
  localparam logic [LW-1:0] FULL_L = LW'(DEPTH);

  txstat_t nx;

  always_comb begin
    nx = st;
    if (uclr) nx.underrun = 1'b0;
    if (wr_evt) begin
      if (lvl_nxt != '0)     begin nx.empty = 1'b0; nx.underrun = 1'b0; end
      if (lvl_nxt >= HALF_L) nx.half_empty = 1'b0;
      if (lvl_nxt >= FULL_L) nx.full = 1'b1;
    end
    if (pop_evt) begin
      nx.full = 1'b0;
      if (lvl_nxt <= HALF_L) nx.half_empty = 1'b1;
      if (lvl_nxt == '0)     begin nx.empty = 1'b1; nx.underrun = 1'b1; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st <= STAT_RESET;
    else if (flush) st <= STAT_RESET;
    else            st <= nx;
  end
endmodule

// File: rtl/atx_txfifo.sv
module atx_txfifo
  import atx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [2:0]  bus_raddr,
  output logic [31:0] bus_rdata,
  output logic        pair_valid,
  input  logic        pair_ready,
  output logic [19:0] pair_left,
  output logic [19:0] pair_right,
  output logic        irq
);
  localparam int LW = $clog2(DEPTH) + 1;
  localparam logic [LW-1:0] HALF_L  = LW'(DEPTH / 2);
  localparam logic [LW:0]   DEPTH_X = (LW+1)'(DEPTH);

  txctl_t        ctl;
  logic          ifen;
  logic [2:0]    ien;
  txstat_t       st;
  logic [LW-1:0] level, level_nxt;
  smp_t          s0, s1;
  logic          two, accept, drain_q, pop;
  logic [1:0]    push_cnt;

  // named internal events
  logic soft_clr, data_wr, uclr, tx_gate, st_full, st_empty;
  logic [2:0] isr;

  assign soft_clr = bus_wr && (bus_addr == ADR_IFCTL) && !bus_wdata[0];
  assign data_wr  = bus_wr && (bus_addr == ADR_DATA);
  assign uclr     = bus_wr && (bus_addr == ADR_ICLR) && bus_wdata[0];
  assign tx_gate  = ctl.tx_en && (ctl.slot3 || ctl.slot4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0; ifen <= 1'b0; ien <= '0; drain_q <= 1'b0;
    end else if (soft_clr) begin
      ctl <= '0; ifen <= 1'b0; ien <= '0; drain_q <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == ADR_TXCTL) ctl  <= txctl_t'(bus_wdata[5:0]);
      if (bus_wr && bus_addr == ADR_IFCTL) ifen <= bus_wdata[0];
      if (bus_wr && bus_addr == ADR_IEN)   ien  <= bus_wdata[2:0];
      drain_q <= pop;
    end
  end

  atx_packer u_pack (.ctl(ctl), .word(bus_wdata), .s0(s0), .s1(s1), .two(two));

  always_comb begin
    if (two) accept = ((LW+1)'(level) + (LW+1)'(2)) < DEPTH_X;
    else     accept = (LW+1)'(level) < DEPTH_X;
    push_cnt = (data_wr && accept) ? (two ? 2'd2 : 2'd1) : 2'd0;
  end

  assign pair_valid = tx_gate && (level >= LW'(2)) && (drain_q || level >= HALF_L);
  assign pop        = pair_valid && pair_ready;

  atx_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .flush(soft_clr), .push_cnt(push_cnt),
    .d0(s0), .d1(s1), .pop(pop), .head0(pair_left), .head1(pair_right),
    .level(level), .level_nxt(level_nxt)
  );

  atx_status #(.DEPTH(DEPTH)) u_stat (
    .clk(clk), .rst_n(rst_n), .flush(soft_clr), .wr_evt(data_wr),
    .pop_evt(pop), .uclr(uclr), .lvl_nxt(level_nxt), .st(st)
  );

  assign st_full  = st.full;
  assign st_empty = st.empty;
  assign isr = {st.empty && !pair_valid, st.underrun, st.half_empty};
  assign irq = |(isr & ien);

  always_comb begin
    case (bus_raddr)
      ADR_TXCTL: bus_rdata = {26'b0, ctl};
      ADR_IFCTL: bus_rdata = {31'b0, ifen};
      ADR_IEN:   bus_rdata = {29'b0, ien};
      ADR_STAT:  bus_rdata = {27'b0, st};
      ADR_ISTAT: bus_rdata = {29'b0, isr};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/atx_chk.sv
module atx_chk #(
  parameter  int DEPTH = 8,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic [LW-1:0] level,
  input logic          pair_valid,
  input logic          pair_ready,
  input logic [19:0]   pair_left,
  input logic [19:0]   pair_right,
  input logic          tx_gate,
  input logic          st_full,
  input logic          st_empty,
  input logic [1:0]    push_cnt
);
  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  assert_pair_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (level >= LW'(2)) && tx_gate);

  assert_refused_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && !pair_ready && !flush) |=> $stable(pair_left) && $stable(pair_right));

  assert_pop_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && pair_ready && push_cnt == 2'd0 && !flush) |=> level == $past(level) - LW'(2));

  assert_full_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_full |-> level == LW'(DEPTH));

  assert_empty_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_empty |-> level == '0);
endmodule

bind atx_txfifo atx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(soft_clr), .level(level),
  .pair_valid(pair_valid), .pair_ready(pair_ready),
  .pair_left(pair_left), .pair_right(pair_right), .tx_gate(tx_gate),
  .st_full(st_full), .st_empty(st_empty), .push_cnt(push_cnt)
);

// File: tb/sim_atx_txfifo.sv
module sim_atx_txfifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [2:0]  bus_raddr = '0;
  logic [31:0] bus_rdata;
  logic        pair_valid, pair_ready = 1'b0, irq;
  logic [19:0] pair_left, pair_right;

  int nchk = 0, nerr = 0;
  int got_l [64];
  int got_r [64];
  int got_n = 0;
  int exp_s [32];
  int exp_n = 0;

  always #4 clk = ~clk;

  atx_txfifo #(.DEPTH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .pair_valid(pair_valid), .pair_ready(pair_ready),
    .pair_left(pair_left), .pair_right(pair_right), .irq(irq)
  );

  // transfer monitor: inputs change just after posedge, so negedge is stable
  always @(negedge clk)
    if (rst_n && pair_valid && pair_ready && got_n < 64) begin
      got_l[got_n] = int'(pair_left);
      got_r[got_n] = int'(pair_right);
      got_n++;
    end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk);
    bus_raddr = a;
    #1 d = int'(bus_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int pad_nc(input int code, input logic [31:0] v);
    longint unsigned m;
    m = (code == 0) ? 16 : (code == 1) ? 4 : (code == 2) ? 1 : 256;
    return int'((longint'(v) * m) % 64'd1048576);
  endfunction

  function automatic int pad_pk(input int code, input logic [15:0] h);
    longint unsigned m;
    m = (code == 3) ? 256 : 16;
    return int'((longint'(h) * m) % 64'd1048576);
  endfunction

  task automatic restart;
    wr(3'd1, 32'd0);
    wr(3'd1, 32'd1);
    got_n = 0;
    exp_n = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int d, lvl, w, k, sweep_ctl;
    logic [31:0] v;
    bit twoeff;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R10 reset state
    rd(3'd5, d); chk("R10 status after reset", d, 32'h13);
    rd(3'd6, d); chk("R8 raw interrupts after reset", d, 5);
    chk("R8 irq masked after reset", int'(irq), 0);
    chk("R10 no pair after reset", int'(pair_valid), 0);

    // R1 R2 R3 R4 R5 R7: sweep widths and packed mode
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 2; c++) begin
        restart();
        pair_ready = 1'b1;
        twoeff = (c == 1) && (s == 0 || s == 3);
        sweep_ctl = (1 << 4) | (c << 3) | (s << 1);
        wr(3'd0, sweep_ctl);
        lvl = 0;
        for (k = 0; k < 9; k++) begin
          v = 32'h1357_9BDF + k * 32'h2468_ACE1 + s * 32'h0101_0101;
          wr(3'd2, v);
          if (twoeff) begin
            if (lvl + 2 < 8) begin
              exp_s[exp_n++] = pad_pk(s, v[15:0]);
              exp_s[exp_n++] = pad_pk(s, v[31:16]);
              lvl += 2;
            end
          end else if (lvl < 8) begin
            exp_s[exp_n++] = pad_nc(s, v);
            lvl++;
          end
        end
        rd(3'd5, d);
        chk(twoeff ? "R3 R4 packed fill status" : "R3 R4 single fill status",
            d, twoeff ? 32'h10 : 32'h14);
        chk("R5 no pair while transmit disabled", got_n, 0);
        wr(3'd0, sweep_ctl | 1);
        idle(10);
        chk("R3 R5 pair count after drain", got_n, exp_n / 2);
        for (int i = 0; i < exp_n / 2; i++) begin
          chk(twoeff ? "R2 R5 left sample" : "R1 R5 left sample", got_l[i], exp_s[2*i]);
          chk(twoeff ? "R2 R5 right sample" : "R1 R5 right sample", got_r[i], exp_s[2*i+1]);
        end
        rd(3'd5, d); chk("R7 status after drain to zero", d, 32'h1B);
        rd(3'd6, d); chk("R8 raw interrupts when drained", d, 7);
      end
    end

    // R5 start threshold
    restart();
    pair_ready = 1'b1;
    wr(3'd0, 32'h25);  // enable, width 20, slot 4
    for (k = 0; k < 3; k++) wr(3'd2, 32'h100 + k);
    idle(4);
    chk("R5 no pair below half depth", got_n, 0);
    chk("R5 valid low below half depth", int'(pair_valid), 0);
    wr(3'd2, 32'h103);
    idle(6);
    chk("R5 two pairs once half depth reached", got_n, 2);
    chk("R5 pair order", got_l[1], 32'h102);

    // R6 refusal ends burst
    restart();
    pair_ready = 1'b0;
    wr(3'd0, 32'h25);
    for (k = 0; k < 4; k++) wr(3'd2, 32'hA0 + k);
    idle(3);
    chk("R6 pair held while refused", int'(pair_valid), 1);
    chk("R6 nothing taken while refused", got_n, 0);
    @(posedge clk); #1 pair_ready = 1'b1;
    @(posedge clk); #1 pair_ready = 1'b0;
    idle(4);
    chk("R6 one pair taken", got_n, 1);
    chk("R6 first pair left", got_l[0], 32'hA0);
    chk("R6 first pair right", got_r[0], 32'hA1);
    chk("R6 burst ended after refusal", int'(pair_valid), 0);
    pair_ready = 1'b1;
    wr(3'd2, 32'hA4);
    idle(3);
    chk("R6 no restart at level three", got_n, 1);
    wr(3'd2, 32'hA5);
    idle(6);
    chk("R6 restart at half depth", got_n, 3);
    chk("R6 resumed order", got_l[1], 32'hA2);
    chk("R6 resumed order tail", got_r[2], 32'hA5);

    // R8 R9 interrupts and underrun clear
    rd(3'd5, d); chk("R7 underrun after drain", d, 32'h1B);
    wr(3'd4, 32'h2);
    idle(1);
    chk("R8 irq from underrun", int'(irq), 1);
    wr(3'd3, 32'h1);
    rd(3'd5, d); chk("R9 underrun cleared", d, 32'h13);
    chk("R8 irq drops after clear", int'(irq), 0);
    rd(3'd6, d); chk("R9 raw interrupt upper bits zero", d, 5);
    wr(3'd4, 32'h1);
    idle(1);
    chk("R8 irq from half-empty", int'(irq), 1);
    pair_ready = 1'b0;
    wr(3'd2, 32'h7);
    rd(3'd5, d); chk("R4 status after one write", d, 32'h12);
    rd(3'd6, d); chk("R8 complete bit off with data", d, 1);
    for (k = 0; k < 3; k++) wr(3'd2, 32'h8 + k);
    rd(3'd5, d); chk("R4 half-empty cleared at half depth", d, 32'h10);
    chk("R8 irq low when half-empty clear", int'(irq), 0);

    // R5 slot gating
    restart();
    pair_ready = 1'b1;
    wr(3'd0, 32'h05);  // enabled, no slot
    for (k = 0; k < 5; k++) wr(3'd2, k);
    idle(4);
    chk("R5 no pair without slot", int'(pair_valid), 0);
    chk("R5 nothing sent without slot", got_n, 0);

    // R10 interface clear
    wr(3'd4, 32'h7);
    wr(3'd1, 32'd0);
    rd(3'd5, d); chk("R10 status after interface clear", d, 32'h13);
    rd(3'd0, d); chk("R10 control zeroed", d, 0);
    rd(3'd4, d); chk("R10 enable mask zeroed", d, 0);
    chk("R10 irq low after clear", int'(irq), 0);
    w = got_n;
    wr(3'd0, 32'h25);
    idle(4);
    chk("R10 FIFO emptied by clear", got_n, w);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule